// File: doc/BRIEF.md
# Synthesizer Programming Port over I2C

This block is a write-only I2C slave that sits in front of a frequency synthesizer and holds its programming state. It runs on the system clock and samples the bus lines through synchronizers. From each line it derives SCL edges and START and STOP conditions. After every START it takes the first byte as a device address. It compares that byte with a fixed 7-bit base address, whose two low bits come from a strap input, followed by a write direction bit.

On a match the block pulls SDA low for the acknowledge clock. It then accepts up to four data bytes and acknowledges each one. The first two bytes form a 15-bit divider word, which is committed to the output in one step after the second byte. The third byte carries three control flags. The fourth byte sets five port output bits.

A STOP or a repeated START ends the sequence. Bytes already completed stay latched, and the next byte after a START is again treated as an address.

Top module: `synth_i2c_ctrl`

## Requirements
- R1: While reset is high and after its release, the divider word, the control flags and the port bits are all zero and `sda_oe_o` is low.
- R2: An address byte equal to {BASE_ADDR[6:2], addr_sel_i, 0} (MSB first, bit 0 = direction, 0 = write) is acknowledged: `sda_oe_o` is high while SCL is high during the ninth clock.
- R3: Any other address byte, including one with the direction bit set, is not acknowledged. All following bytes are neither acknowledged nor stored until the next START.
- R4: After a matching address, each of the first four data bytes is acknowledged in its ninth clock.
- R5: Data byte 1 bits 6:0 give divider bits 14:8, and its bit 7 is ignored. Data byte 2 gives divider bits 7:0. `div_o` changes only once the second byte is complete, so a sequence that ends after byte 1 leaves `div_o` unchanged.
- R6: Data byte 3 bit 0 drives `pump_hi_o`, bit 1 drives `presc_bypass_o` and bit 2 drives `ref_div_long_o`. Its bits 7:3 are ignored.
- R7: Data byte 4 bits 4:0 drive `port_o[4:0]`. Its bits 7:5 are ignored.
- R8: A fifth or later data byte in the same sequence is not acknowledged and changes no output.
- R9: A STOP or a repeated START releases SDA and restarts the sequence at the address byte. Bytes completed before it remain latched, and bytes not reached keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| addr_sel_i | input | 2 | Strap selecting the two low address bits |
| sda_oe_o | output | 1 | High to pull SDA low (acknowledge) |
| div_o | output | 15 | Latched divider word |
| pump_hi_o | output | 1 | High charge-pump current select |
| presc_bypass_o | output | 1 | Prescaler bypass |
| ref_div_long_o | output | 1 | Long reference division ratio select |
| port_o | output | 5 | Port output bits |

## Verification
Two events can fall on the same sequence: the divider commit that follows the second divider byte, and the abort caused by a STOP or a repeated START. The bench provokes this with STOPs and repeated STARTs placed straight after byte 1, straight after byte 2, and after random byte counts. It judges `div_o` after the sequence ends. An abort after byte 1 must leave the word unchanged. An abort after byte 2 must show the full new word, never one half of it.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RECV   = 2'd1,
    ST_ACK    = 2'd2,
    ST_IGNORE = 2'd3
  } bus_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sh, sda_sh;
  logic scl_p, sda_p;
  logic scl_s, sda_s;

  assign scl_s = scl_sh[MSB];
  assign sda_s = sda_sh[MSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh     <= '1;
      sda_sh     <= '1;
      scl_p      <= 1'b1;
      sda_p      <= 1'b1;
      sda_o      <= 1'b1;
      scl_rise_o <= 1'b0;
      scl_fall_o <= 1'b0;
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
    end else begin
      scl_sh     <= {scl_sh[MSB-1:0], scl_i};
      sda_sh     <= {sda_sh[MSB-1:0], sda_i};
      scl_p      <= scl_s;
      sda_p      <= sda_s;
      sda_o      <= sda_s;
      scl_rise_o <= scl_s & ~scl_p;
      scl_fall_o <= ~scl_s & scl_p;
      start_o    <= scl_s & scl_p & sda_p & ~sda_s;
      stop_o     <= scl_s & scl_p & ~sda_p & sda_s;
    end
  end

  // R9
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> !stop_o);
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import synth_i2c_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR  = 7'b1100000,
  parameter int         SEL_W      = 2,
  parameter int         NUM_DATA   = 4,
  parameter int         IDX_W      = $clog2(NUM_DATA + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [SEL_W-1:0]  addr_sel_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);

  bus_state_t        state_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [IDX_W-1:0]  byte_idx_q;
  logic [BYTE_W-1:0] own_addr;

  assign own_addr = {BASE_ADDR[6:SEL_W], addr_sel_i, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      byte_idx_q <= '0;
      sda_oe_o   <= 1'b0;
      wr_stb_o   <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (start_i) begin
        state_q    <= ST_RECV;
        bit_cnt_q  <= '0;
        byte_idx_q <= '0;
        sda_oe_o   <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (state_q)
          ST_RECV: begin
            if (scl_rise_i && bit_cnt_q < BITS_PER_BYTE) begin
              shreg_q   <= {shreg_q[BYTE_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == BITS_PER_BYTE) begin
              if (byte_idx_q == '0) begin
                if (shreg_q == own_addr) begin
                  sda_oe_o   <= 1'b1;
                  state_q    <= ST_ACK;
                  byte_idx_q <= byte_idx_q + 1'b1;
                end else begin
                  state_q <= ST_IGNORE;
                end
              end else if (byte_idx_q <= IDX_W'(NUM_DATA)) begin
                sda_oe_o   <= 1'b1;
                state_q    <= ST_ACK;
                wr_stb_o   <= 1'b1;
                wr_idx_o   <= byte_idx_q;
                wr_data_o  <= shreg_q;
                byte_idx_q <= byte_idx_q + 1'b1;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o  <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ST_RECV;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> $past(scl_fall_i));

  // R3
  ignore_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IGNORE) |=> !wr_stb_o);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (!sda_oe_o && state_q == ST_IDLE));

  // R8
  wr_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> (wr_idx_o >= IDX_W'(1) && wr_idx_o <= IDX_W'(NUM_DATA)));

  // R4
  bit_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt_q <= BITS_PER_BYTE);
endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
  import synth_i2c_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int CTRL_W = 3,
  parameter int PORT_W = 5,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [PORT_W-1:0] port_o
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic [HI_W-1:0] hi_stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_stage_q <= '0;
      div_o      <= '0;
      ctrl_o     <= '0;
      port_o     <= '0;
    end else if (wr_stb_i) begin
      case (wr_idx_i)
        IDX_W'(1): hi_stage_q <= wr_data_i[HI_W-1:0];
        IDX_W'(2): div_o      <= {hi_stage_q, wr_data_i};
        IDX_W'(3): ctrl_o     <= wr_data_i[CTRL_W-1:0];
        IDX_W'(4): port_o     <= wr_data_i[PORT_W-1:0];
        default: ;
      endcase
    end
  end

  // R5
  div_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_o) |-> $past(wr_stb_i && wr_idx_i == IDX_W'(2)));

  // R6
  ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_o) |-> $past(wr_stb_i && wr_idx_i == IDX_W'(3)));

  // R7
  port_write_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(port_o) |-> $past(wr_stb_i && wr_idx_i == IDX_W'(4)));
endmodule

// File: rtl/synth_i2c_ctrl.sv
module synth_i2c_ctrl
  import synth_i2c_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR   = 7'b1100000,
  parameter int         SEL_W       = 2,
  parameter int         DIV_W       = 15,
  parameter int         PORT_W      = 5,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] addr_sel_i,
  output logic             sda_oe_o,
  output logic [DIV_W-1:0] div_o,
  output logic             pump_hi_o,
  output logic             presc_bypass_o,
  output logic             ref_div_long_o,
  output logic [PORT_W-1:0] port_o
);
  localparam int NUM_DATA = 4;
  localparam int CTRL_W   = 3;
  localparam int IDX_W    = $clog2(NUM_DATA + 2);

  logic              sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic              wr_stb;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [CTRL_W-1:0] ctrl;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_p), .stop_o(stop_p)
  );

  i2c_byte_engine #(
    .BASE_ADDR(BASE_ADDR), .SEL_W(SEL_W), .NUM_DATA(NUM_DATA), .IDX_W(IDX_W)
  ) engine_i (
    .clk(clk), .rst(rst), .sda_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start_p), .stop_i(stop_p),
    .addr_sel_i(addr_sel_i), .sda_oe_o(sda_oe_o), .wr_stb_o(wr_stb),
    .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  synth_reg_bank #(
    .DIV_W(DIV_W), .CTRL_W(CTRL_W), .PORT_W(PORT_W), .IDX_W(IDX_W)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_stb_i(wr_stb), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .div_o(div_o), .ctrl_o(ctrl), .port_o(port_o)
  );

  assign pump_hi_o      = ctrl[0];
  assign presc_bypass_o = ctrl[1];
  assign ref_div_long_o = ctrl[2];
endmodule

// File: tb/synth_i2c_ctrl_tb_top.sv
module synth_i2c_ctrl_tb_top;
  localparam logic [6:0] BASE = 7'b1100000;
  localparam int Q = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        scl_drv = 1'b1, sda_drv = 1'b1;
  logic [1:0]  addr_sel = 2'd0;
  logic        sda_oe;
  logic [14:0] div;
  logic        pump_hi, presc_bypass, ref_long;
  logic [4:0]  port;
  wire         sda_line = sda_drv & ~sda_oe;

  synth_i2c_ctrl dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .sda_oe_o(sda_oe), .div_o(div),
    .pump_hi_o(pump_hi), .presc_bypass_o(presc_bypass),
    .ref_div_long_o(ref_long), .port_o(port)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [14:0] exp_div = '0;
  logic [6:0]  exp_stage = '0;
  logic [2:0]  exp_ctrl = '0;
  logic [4:0]  exp_port = '0;
  logic [7:0]  dbuf [0:5];

  function automatic logic [7:0] own_addr(input logic [1:0] s);
    return {BASE[6:2], s, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; wait_clk(Q);
    scl_drv = 1'b1; wait_clk(Q);
    sda_drv = 1'b0; wait_clk(Q);
    scl_drv = 1'b0; wait_clk(Q);
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; wait_clk(Q);
    scl_drv = 1'b1; wait_clk(Q);
    sda_drv = 1'b1; wait_clk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wait_clk(Q);
      scl_drv = 1'b1; wait_clk(2 * Q);
      scl_drv = 1'b0; wait_clk(Q);
    end
    sda_drv = 1'b1; wait_clk(Q);
    scl_drv = 1'b1; wait_clk(Q);
    ack = ~sda_line; wait_clk(Q);
    scl_drv = 1'b0; wait_clk(Q);
  endtask

  task automatic check_outputs(input string ctx);
    chk({ctx, " R5 divider"}, 32'(div), 32'(exp_div));
    chk({ctx, " R6 control"}, 32'({ref_long, presc_bypass, pump_hi}), 32'(exp_ctrl));
    chk({ctx, " R7 port"}, 32'(port), 32'(exp_port));
    chk({ctx, " R9 sda released"}, 32'(sda_oe), 32'd0);
  endtask

  task automatic run_txn(input logic [7:0] a, input int n, input bit do_stop, input string ctx);
    logic ack;
    bit   matched;
    matched = (a == own_addr(addr_sel));
    i2c_start();
    send_byte(a, ack);
    chk(matched ? {ctx, " R2 address ack"} : {ctx, " R3 address nack"}, 32'(ack), 32'(matched));
    for (int i = 1; i <= n; i++) begin
      bit exp_ack;
      exp_ack = matched && (i <= 4);
      send_byte(dbuf[i-1], ack);
      chk(!matched ? {ctx, " R3 data nack"} : (i <= 4 ? {ctx, " R4 data ack"} : {ctx, " R8 extra nack"}),
          32'(ack), 32'(exp_ack));
      if (exp_ack) begin
        case (i)
          1: exp_stage = dbuf[0][6:0];
          2: exp_div   = {exp_stage, dbuf[1]};
          3: exp_ctrl  = dbuf[2][2:0];
          4: exp_port  = dbuf[3][4:0];
          default: ;
        endcase
      end
    end
    if (do_stop) i2c_stop();
    wait_clk(2 * Q);
    check_outputs(ctx);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd1234);
    wait_clk(5);
    // R1: reset state
    chk("R1 sda during reset", 32'(sda_oe), 32'd0);
    rst = 1'b0;
    wait_clk(5);
    chk("R1 divider after reset", 32'(div), 32'd0);
    chk("R1 control after reset", 32'({ref_long, presc_bypass, pump_hi}), 32'd0);
    chk("R1 port after reset", 32'(port), 32'd0);

    // Full programming, bit 7 of byte 1 must be dropped (R5)
    addr_sel = 2'd2;
    dbuf[0] = 8'h85; dbuf[1] = 8'h3C; dbuf[2] = 8'hFF; dbuf[3] = 8'hFF;
    run_txn(own_addr(addr_sel), 4, 1'b1, "full");
    chk("R5 direct divider value", 32'(div), 32'h053C);

    // R5: only byte 1, then STOP: divider unchanged
    dbuf[0] = 8'h2A;
    run_txn(own_addr(addr_sel), 1, 1'b1, "half");
    chk("R5 no partial commit", 32'(div), 32'h053C);

    // R9: byte 1 then repeated START into a two-byte write
    dbuf[0] = 8'h11;
    run_txn(own_addr(addr_sel), 1, 1'b0, "rs1");
    dbuf[0] = 8'h7E; dbuf[1] = 8'h01;
    run_txn(own_addr(addr_sel), 2, 1'b1, "rs2");

    // R9: three bytes, port keeps its value
    dbuf[0] = 8'h00; dbuf[1] = 8'h99; dbuf[2] = 8'h02;
    run_txn(own_addr(addr_sel), 3, 1'b1, "three");
    chk("R9 port kept", 32'(port), 32'h1F);

    // R8: six data bytes
    dbuf[0] = 8'h12; dbuf[1] = 8'h34; dbuf[2] = 8'h05; dbuf[3] = 8'h0A;
    dbuf[4] = 8'hFF; dbuf[5] = 8'hFF;
    run_txn(own_addr(addr_sel), 6, 1'b1, "extra");

    // R3: wrong strap value, then read direction bit
    dbuf[0] = 8'h7F; dbuf[1] = 8'hFF; dbuf[2] = 8'hFF; dbuf[3] = 8'hFF;
    run_txn(own_addr(2'd1), 4, 1'b1, "wrong_sel");
    run_txn(own_addr(addr_sel) | 8'h01, 4, 1'b1, "read_bit");

    // Random mix
    for (int t = 0; t < 30; t++) begin
      logic [7:0] a;
      if ($urandom_range(0, 7) == 0) addr_sel = 2'($urandom_range(0, 3));
      a = ($urandom_range(0, 3) != 0) ? own_addr(addr_sel) : 8'($urandom_range(0, 255));
      for (int k = 0; k < 6; k++) dbuf[k] = 8'($urandom_range(0, 255));
      run_txn(a, $urandom_range(0, 6), 1'($urandom_range(0, 1)), "rand");
    end
    i2c_stop();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule